// File: doc/BRIEF.md
# Dual Quadrature Phase Counter with 32-bit Linking

This block tracks the position of one or two incremental encoders. Each channel takes a pair of quadrature pins. The pins pass through a two-flop synchronizer and then a digital filter, which accepts a new level only after it has held for a programmed number of samples. A Gray-code decoder then turns every legal transition of the filtered pair into one step up or one step down. In the default mode each channel keeps its own 16-bit count. When the link bit is set, the two counts act as the low and high halves of a single 32-bit count that channel 0's pins drive.

Software-side control arrives on plain ports. A write strobe with a half select loads either count. Per-channel compare values and enables clear a count when it matches. Per-channel capture strobes copy a count into a capture register and can also clear it. Each channel drives registered one-cycle overflow and underflow pulses and a sticky flag that marks illegal transitions.

Top module: `quad_phase_counter`

## Requirements
- R1: Decoding is 4x. With a channel's pins read as {A,B}, each legal transition in the cycle 00→10→11→01→00 adds one to the count, and each transition in the reverse direction subtracts one.
- R2: With `link_en` low, `count[0]` follows only channel 0's pins and `count[1]` follows only channel 1's pins. Each count wraps modulo 2^16.
- R3: With `link_en` high, {`count[1]`,`count[0]`} forms one 32-bit count that channel 0's pins drive. The carry or borrow reaches the high half on the same edge. Motion on channel 1's pins leaves both halves unchanged.
- R4: With `link_en` low, a step up from FFFF to 0000 gives a one-cycle pulse on `ovf[i]`, and a step down from 0000 to FFFF gives a one-cycle pulse on `unf[i]`. No other step pulses either flag.
- R5: With `link_en` high, `ovf[1]` and `unf[1]` pulse only when the full 32-bit count wraps. `ovf[0]` and `unf[0]` stay low, including when the low half carries.
- R6: A transition in which both filtered pins of a channel change at once leaves the count unchanged and sets `err[i]`. `err[i]` stays set until reset and does not affect the other channel's flag.
- R7: The filter passes a new pin level only after that level has been sampled on `filt_len` consecutive clocks. A pulse that lasts fewer samples produces no count. A `filt_len` of 0 acts as 1.
- R8: A legal pin change made between clock edges changes the count on the (3+L)-th rising edge after it, where L is the effective filter length.
- R9: When clear-on-compare is enabled, the edge after the count equals its compare value loads zero. Independent mode uses `cmp_val[i]` and `cmp_clr_en[i]`. Linked mode compares the 32-bit count with {`cmp_val[1]`,`cmp_val[0]`} under `cmp_clr_en[0]` and clears both halves.
- R10: A high `cap_in[i]` at an edge copies the count as it was before that edge into `cap_val[i]`. If `cap_clr_en[i]` is also set, the count is cleared on that edge. In linked mode `cap_in[0]` captures and clears both halves, and `cap_in[1]` has no effect.
- R11: On any one edge a clear (compare or capture) wins over a write, and a write (`wr_en`, half chosen by `wr_sel`, data `wr_data`) wins over a step.
- R12: After reset both counts, both capture values and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_a | input | 2 | A pin of each channel |
| pin_b | input | 2 | B pin of each channel |
| filt_len | input | FW | Required stable samples for the filter (0 acts as 1) |
| link_en | input | 1 | Join both channels into one 32-bit count |
| wr_en | input | 1 | Load strobe for a count half |
| wr_sel | input | 1 | Selects which count half is loaded |
| wr_data | input | CW | Load value |
| cmp_val | input | 2xCW | Compare value per channel |
| cmp_clr_en | input | 2 | Clear-on-compare enable per channel |
| cap_in | input | 2 | Capture strobe per channel |
| cap_clr_en | input | 2 | Clear-on-capture enable per channel |
| count | output | 2xCW | Current counts |
| cap_val | output | 2xCW | Captured counts |
| ovf | output | 2 | Overflow pulse per channel |
| unf | output | 2 | Underflow pulse per channel |
| err | output | 2 | Sticky illegal-transition flag per channel |

## Verification
The hardest case to reach is a write and a decoded step landing on the same clock edge, because the step emerges several registers after the pin change. The bench first pins down the exact latency for each filter length, checking the count one edge before and one edge after the expected change. It then places the write strobe on the one edge where the step lands. Linked wraps are reached by loading both halves to FFFF before stepping, which avoids walking through 2^32 states.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2,
    STEP_BAD  = 2'd3
  } step_e;

  // forward Gray order on {A,B}: 00 -> 10 -> 11 -> 01 -> 00
  function automatic logic [1:0] gray_fwd(input logic [1:0] s);
    case (s)
      2'b00:   gray_fwd = 2'b10;
      2'b10:   gray_fwd = 2'b11;
      2'b11:   gray_fwd = 2'b01;
      default: gray_fwd = 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/qpc_filter.sv
module qpc_filter #(
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          raw,
  input  logic [FW-1:0] len,
  output logic          lvl
);
  logic          s1_q, s2_q;
  logic [FW-1:0] run_q;
  logic [FW:0]   run_inc;

  assign run_inc = {1'b0, run_q} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      run_q <= '0;
      lvl   <= 1'b0;
    end else begin
      s1_q <= raw;
      s2_q <= s1_q;
      if (s2_q == lvl) begin
        run_q <= '0;
      end else if (run_inc >= {1'b0, len}) begin
        lvl   <= s2_q;
        run_q <= '0;
      end else begin
        run_q <= run_inc[FW-1:0];
      end
    end
  end

  // R7
  filter_pass_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(lvl) |-> lvl == $past(s2_q));
endmodule

// File: rtl/qpc_decode.sv
module qpc_decode
  import qpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] ab,
  output step_e      step,
  output logic       err
);
  logic [1:0] prev_q;

  always_comb begin
    if (ab == prev_q)                 step = STEP_NONE;
    else if ((ab ^ prev_q) == 2'b11)  step = STEP_BAD;
    else if (gray_fwd(prev_q) == ab)  step = STEP_UP;
    else                              step = STEP_DN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 2'b00;
      err    <= 1'b0;
    end else begin
      prev_q <= ab;
      if (step == STEP_BAD) err <= 1'b1;
    end
  end

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
endmodule

// File: rtl/quad_phase_counter.sv
module quad_phase_counter
  import qpc_pkg::*;
#(
  parameter int CW = 16,
  parameter int FW = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          pin_a,
  input  logic [1:0]          pin_b,
  input  logic [FW-1:0]       filt_len,
  input  logic                link_en,
  input  logic                wr_en,
  input  logic                wr_sel,
  input  logic [CW-1:0]       wr_data,
  input  logic [1:0][CW-1:0]  cmp_val,
  input  logic [1:0]          cmp_clr_en,
  input  logic [1:0]          cap_in,
  input  logic [1:0]          cap_clr_en,
  output logic [1:0][CW-1:0]  count,
  output logic [1:0][CW-1:0]  cap_val,
  output logic [1:0]          ovf,
  output logic [1:0]          unf,
  output logic [1:0]          err
);
  localparam int NCH = 2;
  localparam int WW  = 2 * CW;
  localparam logic [CW-1:0] HALF_MAX = {CW{1'b1}};
  localparam logic [WW-1:0] WIDE_MAX = {WW{1'b1}};

  step_e                stp [NCH];
  logic [NCH-1:0][CW-1:0] cnt_q, cnt_d, cap_q, cap_d;
  logic [NCH-1:0]       ovf_q, ovf_d, unf_q, unf_d;
  logic [WW-1:0]        wide, cmp_wide;
  logic                 clr_all;
  logic [NCH-1:0]       clr_ch;

  for (genvar g = 0; g < NCH; g++) begin : g_front
    logic fa, fb;
    qpc_filter #(.FW(FW)) u_fa (.clk(clk), .rst(rst), .raw(pin_a[g]), .len(filt_len), .lvl(fa));
    qpc_filter #(.FW(FW)) u_fb (.clk(clk), .rst(rst), .raw(pin_b[g]), .len(filt_len), .lvl(fb));
    qpc_decode u_dec (.clk(clk), .rst(rst), .ab({fa, fb}), .step(stp[g]), .err(err[g]));
  end

  assign wide     = {cnt_q[1], cnt_q[0]};
  assign cmp_wide = {cmp_val[1], cmp_val[0]};
  assign clr_all  = (cmp_clr_en[0] && (wide == cmp_wide)) || (cap_in[0] && cap_clr_en[0]);

  always_comb begin
    for (int i = 0; i < NCH; i++)
      clr_ch[i] = (cmp_clr_en[i] && (cnt_q[i] == cmp_val[i])) || (cap_in[i] && cap_clr_en[i]);
  end

  always_comb begin
    cnt_d = cnt_q;
    cap_d = cap_q;
    ovf_d = '0;
    unf_d = '0;
    if (link_en) begin
      if (cap_in[0]) cap_d = cnt_q;
      if (clr_all) begin
        cnt_d = '0;
      end else if (wr_en) begin
        cnt_d[wr_sel] = wr_data;
      end else if (stp[0] == STEP_UP) begin
        {cnt_d[1], cnt_d[0]} = wide + 1'b1;
        ovf_d[1] = (wide == WIDE_MAX);
      end else if (stp[0] == STEP_DN) begin
        {cnt_d[1], cnt_d[0]} = wide - 1'b1;
        unf_d[1] = (wide == '0);
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (cap_in[i]) cap_d[i] = cnt_q[i];
        if (clr_ch[i]) begin
          cnt_d[i] = '0;
        end else if (wr_en && (wr_sel == i[0])) begin
          cnt_d[i] = wr_data;
        end else if (stp[i] == STEP_UP) begin
          cnt_d[i] = cnt_q[i] + 1'b1;
          ovf_d[i] = (cnt_q[i] == HALF_MAX);
        end else if (stp[i] == STEP_DN) begin
          cnt_d[i] = cnt_q[i] - 1'b1;
          unf_d[i] = (cnt_q[i] == '0);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      cap_q <= '0;
      ovf_q <= '0;
      unf_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      cap_q <= cap_d;
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  assign count   = cnt_q;
  assign cap_val = cap_q;
  assign ovf     = ovf_q;
  assign unf     = unf_q;

  // R4
  ovf_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_q[0] |-> cnt_q[0] == '0);
  // R4
  unf_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    unf_q[0] |-> cnt_q[0] == HALF_MAX);
  // R5
  link_low_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(link_en) |-> (ovf_q[0] == 1'b0) && (unf_q[0] == 1'b0));
  // R11
  wr_prio_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_sel && cap_in == 2'b00 && cmp_clr_en == 2'b00) |=> cnt_q[0] == $past(wr_data));
  // R10
  cap_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_in[0] && cap_clr_en[0]) |=> cnt_q[0] == '0);
endmodule

// File: tb/tb_quad_phase_counter.sv
module tb_quad_phase_counter;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;
  localparam int FW = 4;

  logic clk = 1'b0;
  logic rst;
  logic [1:0] pin_a, pin_b;
  logic [FW-1:0] filt_len;
  logic link_en, wr_en, wr_sel;
  logic [CW-1:0] wr_data;
  logic [1:0][CW-1:0] cmp_val;
  logic [1:0] cmp_clr_en, cap_in, cap_clr_en;
  logic [1:0][CW-1:0] count, cap_val;
  logic [1:0] ovf, unf, err;

  int checks = 0;
  int fails = 0;
  int ph [2];
  logic [1:0] seen_ovf, seen_unf;
  logic [CW-1:0] e0, e1;
  logic [7:0] lf;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_phase_counter #(.CW(CW), .FW(FW)) dut (
    .clk(clk), .rst(rst), .pin_a(pin_a), .pin_b(pin_b), .filt_len(filt_len),
    .link_en(link_en), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cmp_val(cmp_val), .cmp_clr_en(cmp_clr_en), .cap_in(cap_in), .cap_clr_en(cap_clr_en),
    .count(count), .cap_val(cap_val), .ovf(ovf), .unf(unf), .err(err));

  function automatic logic [1:0] phase_ab(input int p);
    case (p & 3)
      0: phase_ab = 2'b00;
      1: phase_ab = 2'b10;
      2: phase_ab = 2'b11;
      default: phase_ab = 2'b01;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic restart(input logic [FW-1:0] len, input logic lk);
    @(negedge clk);
    rst = 1'b1; pin_a = 2'b00; pin_b = 2'b00; filt_len = len; link_en = lk;
    wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0; cmp_val = '0; cmp_clr_en = '0;
    cap_in = '0; cap_clr_en = '0; ph[0] = 0; ph[1] = 0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
  endtask

  task automatic drive(input int ch, input int delta);
    logic [1:0] v;
    ph[ch] = (ph[ch] + delta + 4) % 4;
    v = phase_ab(ph[ch]);
    pin_a[ch] = v[1];
    pin_b[ch] = v[0];
  endtask

  task automatic move(input int ch, input int delta);
    seen_ovf = '0; seen_unf = '0;
    drive(ch, delta);
    repeat (int'(filt_len) + 7) begin
      tick();
      seen_ovf |= ovf;
      seen_unf |= unf;
    end
  endtask

  task automatic write_half(input logic sel, input logic [CW-1:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1;
    restart(4'd1, 1'b0);
    // R12 reset state
    chk("R12 count", 64'(count), 64'd0);
    chk("R12 cap", 64'(cap_val), 64'd0);
    chk("R12 flags", {58'd0, ovf, unf, err}, 64'd0);

    // R1 R2 sweep over filter lengths, both channels independent
    lf = 8'h5b;
    foreach (filt_len_list[k]) begin
      restart(filt_len_list[k], 1'b0);
      e0 = '0; e1 = '0;
      for (int s = 0; s < 20; s++) begin
        int d0, d1;
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        d0 = lf[0] ? 1 : -1;
        d1 = lf[1] ? 1 : -1;
        move(0, d0); e0 = e0 + CW'(d0);
        chk("R1 ch0 count", 64'(count[0]), 64'(e0));
        chk("R2 ch1 untouched", 64'(count[1]), 64'(e1));
        move(1, d1); e1 = e1 + CW'(d1);
        chk("R2 ch1 count", 64'(count[1]), 64'(e1));
        chk("R2 ch0 untouched", 64'(count[0]), 64'(e0));
      end
    end

    // R4 independent wrap
    restart(4'd1, 1'b0);
    write_half(1'b0, 16'hFFFF);
    move(0, 1);
    chk("R4 wrap up", 64'(count[0]), 64'd0);
    chk("R4 ovf pulse", 64'({seen_ovf, seen_unf}), 64'b1000 >> 1);
    move(0, -1);
    chk("R4 wrap down", 64'(count[0]), 64'hFFFF);
    chk("R4 unf pulse", 64'({seen_ovf, seen_unf}), 64'b0001);
    move(0, -1);
    chk("R4 no flag mid", 64'({seen_ovf, seen_unf}), 64'd0);

    // R3 R5 linked mode
    restart(4'd2, 1'b1);
    write_half(1'b0, 16'hFFFF);
    write_half(1'b1, 16'h0012);
    move(0, 1);
    chk("R3 carry", 64'({count[1], count[0]}), 64'h0013_0000);
    chk("R5 no flag on carry", 64'({seen_ovf, seen_unf}), 64'd0);
    move(0, -1);
    chk("R3 borrow", 64'({count[1], count[0]}), 64'h0012_FFFF);
    chk("R5 no flag on borrow", 64'({seen_ovf, seen_unf}), 64'd0);
    move(1, 1);
    move(1, 1);
    chk("R3 ch1 pins ignored", 64'({count[1], count[0]}), 64'h0012_FFFF);
    write_half(1'b1, 16'hFFFF);
    move(0, 1);
    chk("R5 32b wrap up", 64'({count[1], count[0]}), 64'd0);
    chk("R5 ovf1 only", 64'({seen_ovf, seen_unf}), 64'b1000);
    move(0, -1);
    chk("R5 32b wrap down", 64'({count[1], count[0]}), 64'hFFFF_FFFF);
    chk("R5 unf1 only", 64'({seen_ovf, seen_unf}), 64'b0010);

    // R6 illegal transition
    restart(4'd1, 1'b0);
    move(0, 1);
    move(0, 2);
    chk("R6 no count on illegal", 64'(count[0]), 64'd1);
    chk("R6 err set", 64'(err), 64'b01);
    move(0, 1);
    chk("R6 counts resume", 64'(count[0]), 64'd2);
    chk("R6 err sticky", 64'(err), 64'b01);

    // R7 filter rejects short pulse
    restart(4'd4, 1'b0);
    pin_a[0] = 1'b1;
    repeat (3) tick();
    pin_a[0] = 1'b0;
    repeat (12) tick();
    chk("R7 short pulse ignored", 64'(count[0]), 64'd0);
    chk("R7 no err from pulse", 64'(err), 64'd0);

    // R8 latency, R7 len 0 acts as 1
    foreach (lat_list[k]) begin
      int eff;
      restart(lat_list[k], 1'b0);
      eff = (lat_list[k] == 0) ? 1 : int'(lat_list[k]);
      drive(0, 1);
      repeat (2 + eff) tick();
      chk("R8 not yet", 64'(count[0]), 64'd0);
      tick();
      chk("R8 on time", 64'(count[0]), 64'd1);
    end

    // R9 compare clear
    restart(4'd1, 1'b0);
    cmp_val[0] = 16'd3;
    move(0, 1); move(0, 1);
    move(0, 1);
    chk("R9 no clear when disabled", 64'(count[0]), 64'd3);
    cmp_clr_en[0] = 1'b1;
    tick();
    chk("R9 clear on match", 64'(count[0]), 64'd0);
    cmp_clr_en[0] = 1'b0;
    restart(4'd1, 1'b1);
    write_half(1'b0, 16'hFFFF);
    cmp_val[1] = 16'd1; cmp_val[0] = 16'd0;
    cmp_clr_en[0] = 1'b1;
    drive(0, 1);
    repeat (4) tick();
    chk("R9 linked reaches compare", 64'({count[1], count[0]}), 64'h0001_0000);
    tick();
    chk("R9 linked clear", 64'({count[1], count[0]}), 64'd0);

    // R10 capture
    restart(4'd1, 1'b0);
    write_half(1'b0, 16'd7);
    cap_in[0] = 1'b1; tick(); cap_in[0] = 1'b0;
    chk("R10 capture value", 64'(cap_val[0]), 64'd7);
    chk("R10 count kept", 64'(count[0]), 64'd7);
    cap_clr_en[0] = 1'b1;
    cap_in[0] = 1'b1; tick(); cap_in[0] = 1'b0;
    chk("R10 capture and clear", 64'({cap_val[0], count[0]}), 64'h0007_0000);
    restart(4'd1, 1'b1);
    write_half(1'b0, 16'h1111);
    write_half(1'b1, 16'h2222);
    cap_clr_en = 2'b11;
    cap_in[1] = 1'b1; tick(); cap_in[1] = 1'b0;
    chk("R10 linked cap1 ignored", 64'({cap_val[1], cap_val[0], count[1], count[0]}), 64'h0000_0000_2222_1111);
    cap_in[0] = 1'b1; tick(); cap_in[0] = 1'b0;
    chk("R10 linked cap0", 64'({cap_val[1], cap_val[0], count[1], count[0]}), 64'h2222_1111_0000_0000);

    // R11 priorities
    restart(4'd1, 1'b0);
    write_half(1'b0, 16'd9);
    cap_clr_en[0] = 1'b1; cap_in[0] = 1'b1;
    write_half(1'b0, 16'h0055);
    cap_in[0] = 1'b0; cap_clr_en[0] = 1'b0;
    chk("R11 clear beats write", 64'(count[0]), 64'd0);
    drive(0, 1);
    repeat (3) tick();
    write_half(1'b0, 16'h0040);
    chk("R11 write beats step", 64'(count[0]), 64'h40);
    repeat (6) tick();
    chk("R11 write holds", 64'(count[0]), 64'h40);
    write_half(1'b1, 16'h0abc);
    chk("R11 wr_sel picks half", 64'({count[1], count[0]}), 64'h0abc_0040);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  localparam logic [FW-1:0] filt_len_list [4] = '{4'd1, 4'd2, 4'd5, 4'd15};
  localparam logic [FW-1:0] lat_list [4] = '{4'd0, 4'd1, 4'd3, 4'd15};
endmodule